// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block sits between a kernel launcher and a row of multiprocessors. Launch requests arrive one at a time on a valid/ready handshake. Each request gives the number of threads in a block and the number of registers each of those threads needs. The dispatcher keeps three running totals for every multiprocessor: how many blocks it holds, how many threads it holds, and how many registers it has handed out. It grants the request at the head of the queue to the lowest-numbered multiprocessor where all three limits still hold. If no multiprocessor has room, it holds the request.

A block's register need is its thread count times its registers per thread. That many registers belong to the block until it completes. A completion pulse gives the multiprocessor index and repeats the block's thread count and registers per thread. The dispatcher subtracts those amounts, which lets a waiting head request go out on a later cycle. A request whose thread count is outside the legal range is taken off the queue and flagged, and it consumes nothing. Granted blocks receive identifiers from a counter that runs in grant order.

Top module: `blk_admit`

## Requirements
- R1: A request with a thread count of 0 or above 512 is accepted (req_ready high) and produces a reject pulse one cycle later. It produces no grant and no change to any resource total.
- R2: A multiprocessor never holds more than 8 resident blocks. A ninth block goes to another multiprocessor, or it waits.
- R3: A multiprocessor never holds more than 768 resident threads. A block that would bring the total to exactly 768 is admitted.
- R4: A block takes threads × registers-per-thread registers from a budget of 8192 per multiprocessor. With 256 threads at 10 registers each, three blocks fit in one multiprocessor. At 11 registers each, only two fit.
- R5: Among the multiprocessors where all three limits pass, the one with the lowest index gets the block.
- R6: Requests are granted in arrival order. While the head request fits nowhere, req_ready stays low, and nothing behind it is granted.
- R7: A grant shows on grant_valid one cycle after the handshake, together with the multiprocessor index and a block identifier. Identifiers count up by one from 0 after reset, with modulo 2^ID_W wrap.
- R8: A completion returns one block slot, its threads and its registers to the named multiprocessor. A head request that was stalled can be granted from the following cycle.
- R9: If a grant and a completion hit the same multiprocessor in the same cycle, both are applied. The fit decision in that cycle uses the totals from before the completion.
- R10: A synchronous active-high reset clears all resource totals, the identifier counter, grant_valid and reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A launch request is present |
| req_ready | output | 1 | The request is taken this cycle (it fits, or it is illegal) |
| req_threads | input | THR_W | Threads in the requested block |
| req_rpt | input | RPT_W | Registers needed per thread |
| grant_valid | output | 1 | Pulse: a block was placed |
| grant_sm | output | SM_W | Multiprocessor that received the block |
| grant_id | output | ID_W | Identifier of the granted block |
| reject | output | 1 | Pulse: an illegal request was dropped |
| done_valid | input | 1 | A resident block has completed |
| done_sm | input | SM_W | Multiprocessor of the completed block |
| done_threads | input | THR_W | Thread count of the completed block |
| done_rpt | input | RPT_W | Registers per thread of the completed block |

## Verification
req_ready is combinational, so it is due in the same cycle the request is presented. grant_valid, grant_sm, grant_id and reject pass through one register and are due one rising edge after the handshake. A completion changes the totals at the edge where it is sampled, so its effect reaches req_ready only in the cycle after that. The bench changes its inputs on the falling edge and reads req_ready 1 ns later. It reads the registered outputs at the next falling edge and compares them with what its arithmetic model expects from the step before.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

   // Outcome of the head request in one cycle
   typedef enum logic [1:0] {
      ADM_HOLD   = 2'd0,
      ADM_GRANT  = 2'd1,
      ADM_REJECT = 2'd2
   } adm_kind_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/blk_admit_pick.sv
module blk_admit_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     mask,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |mask;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/blk_admit_acct.sv
module blk_admit_acct
   import blk_admit_pkg::*;
#(
   parameter int MAX_BLOCKS  = 8,
   parameter int MAX_THREADS = 768,
   parameter int NUM_REGS    = 8192,
   parameter int THR_W       = 10,
   parameter int NEED_W      = 17
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [THR_W-1:0]  q_thr,
   input  logic [NEED_W-1:0] q_regs,
   output logic              fits,
   input  logic              add,
   input  logic              sub,
   input  logic [THR_W-1:0]  sub_thr,
   input  logic [NEED_W-1:0] sub_regs
);
   localparam int BC_W = cnt_width(MAX_BLOCKS);
   localparam int TC_W = cnt_width(MAX_THREADS);
   localparam int RC_W = cnt_width(NUM_REGS);
   localparam int TS_W = ((TC_W > THR_W) ? TC_W : THR_W) + 1;
   localparam int RS_W = ((RC_W > NEED_W) ? RC_W : NEED_W) + 1;

   logic [BC_W-1:0] blk_q;
   logic [TC_W-1:0] thr_q;
   logic [RC_W-1:0] reg_q;
   logic [TS_W-1:0] thr_sum;
   logic [RS_W-1:0] reg_sum;

   always_comb begin
      thr_sum = TS_W'(thr_q) + TS_W'(q_thr);
      reg_sum = RS_W'(reg_q) + RS_W'(q_regs);
      fits    = (blk_q < BC_W'(MAX_BLOCKS)) &&
                (thr_sum <= TS_W'(MAX_THREADS)) &&
                (reg_sum <= RS_W'(NUM_REGS));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         blk_q <= '0;
         thr_q <= '0;
         reg_q <= '0;
      end else begin
         blk_q <= blk_q + BC_W'(add) - BC_W'(sub);
         thr_q <= thr_q + (add ? TC_W'(q_thr) : '0) - (sub ? TC_W'(sub_thr) : '0);
         reg_q <= reg_q + (add ? RC_W'(q_regs) : '0) - (sub ? RC_W'(sub_regs) : '0);
      end
   end

   p_blk_cap_r2: assert property (@(posedge clk) disable iff (rst)
      blk_q <= BC_W'(MAX_BLOCKS));
   p_thr_cap_r3: assert property (@(posedge clk) disable iff (rst)
      thr_q <= TC_W'(MAX_THREADS));
   p_reg_cap_r4: assert property (@(posedge clk) disable iff (rst)
      reg_q <= RC_W'(NUM_REGS));
   p_add_fits_r5: assert property (@(posedge clk) disable iff (rst)
      add |-> fits);
   p_same_sm_r9: assert property (@(posedge clk) disable iff (rst)
      (add && sub) |=> blk_q == $past(blk_q));
   p_free_r8: assert property (@(posedge clk) disable iff (rst)
      (sub && !add) |=> blk_q == $past(blk_q) - BC_W'(1));
endmodule

// File: rtl/blk_admit.sv
module blk_admit
   import blk_admit_pkg::*;
#(
   parameter int NUM_SM          = 4,
   parameter int MAX_BLOCKS      = 8,
   parameter int MAX_THREADS     = 768,
   parameter int NUM_REGS        = 8192,
   parameter int MAX_BLK_THREADS = 512,
   parameter int RPT_W           = 7,
   parameter int ID_W            = 8,
   localparam int THR_W  = cnt_width(MAX_BLK_THREADS),
   localparam int SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
   localparam int NEED_W = THR_W + RPT_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [THR_W-1:0] req_threads,
   input  logic [RPT_W-1:0] req_rpt,
   output logic             grant_valid,
   output logic [SM_W-1:0]  grant_sm,
   output logic [ID_W-1:0]  grant_id,
   output logic             reject,
   input  logic             done_valid,
   input  logic [SM_W-1:0]  done_sm,
   input  logic [THR_W-1:0] done_threads,
   input  logic [RPT_W-1:0] done_rpt
);
   // elaboration-time parameter checks
   if (NUM_SM < 1) begin : g_bad_num_sm
      $error("NUM_SM must be at least 1");
   end
   if (MAX_BLK_THREADS > MAX_THREADS) begin : g_bad_blk_thr
      $error("MAX_BLK_THREADS exceeds MAX_THREADS");
   end
   if (MAX_BLOCKS < 1 || NUM_REGS < 1 || RPT_W < 1 || ID_W < 1) begin : g_bad_sizes
      $error("limits and widths must be positive");
   end

   logic [NEED_W-1:0] req_need;
   logic [NEED_W-1:0] done_need;
   logic              req_bad;
   logic [NUM_SM-1:0] fit_mask;
   logic              any_fit;
   logic [SM_W-1:0]   pick_idx;
   adm_kind_e         kind;
   logic [ID_W-1:0]   id_q;

   assign req_need  = NEED_W'(req_threads) * NEED_W'(req_rpt);
   assign done_need = NEED_W'(done_threads) * NEED_W'(done_rpt);
   assign req_bad   = (req_threads == '0) || (req_threads > THR_W'(MAX_BLK_THREADS));

   for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
      logic add_g;
      logic sub_g;
      assign add_g = (kind == ADM_GRANT) && (pick_idx == SM_W'(g));
      assign sub_g = done_valid && (done_sm == SM_W'(g));
      blk_admit_acct #(
         .MAX_BLOCKS (MAX_BLOCKS),
         .MAX_THREADS(MAX_THREADS),
         .NUM_REGS   (NUM_REGS),
         .THR_W      (THR_W),
         .NEED_W     (NEED_W)
      ) u_acct (
         .clk     (clk),
         .rst     (rst),
         .q_thr   (req_threads),
         .q_regs  (req_need),
         .fits    (fit_mask[g]),
         .add     (add_g),
         .sub     (sub_g),
         .sub_thr (done_threads),
         .sub_regs(done_need)
      );
   end

   blk_admit_pick #(.N(NUM_SM), .IDX_W(SM_W)) u_pick (
      .mask(fit_mask),
      .any (any_fit),
      .idx (pick_idx)
   );

   assign req_ready = !rst && (req_bad || any_fit);

   always_comb begin
      kind = ADM_HOLD;
      if (req_valid && req_ready) kind = req_bad ? ADM_REJECT : ADM_GRANT;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_valid <= 1'b0;
         grant_sm    <= '0;
         grant_id    <= '0;
         reject      <= 1'b0;
         id_q        <= '0;
      end else begin
         grant_valid <= (kind == ADM_GRANT);
         reject      <= (kind == ADM_REJECT);
         if (kind == ADM_GRANT) begin
            grant_sm <= pick_idx;
            grant_id <= id_q;
            id_q     <= id_q + ID_W'(1);
         end
      end
   end

   p_grant_after_hs_r7: assert property (@(posedge clk) disable iff (rst)
      grant_valid |-> $past(req_valid && req_ready));
   p_id_step_r7: assert property (@(posedge clk) disable iff (rst)
      (grant_valid && $past(grant_valid)) |-> grant_id == $past(grant_id) + ID_W'(1));
   p_excl_r1: assert property (@(posedge clk) disable iff (rst)
      !(grant_valid && reject));
   p_reject_src_r1: assert property (@(posedge clk) disable iff (rst)
      reject |-> $past(req_valid && req_ready));
   p_stall_r6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready) |=> !grant_valid && !reject);
   p_pick_fit_r5: assert property (@(posedge clk) disable iff (rst)
      (kind == ADM_GRANT) |-> fit_mask[pick_idx]);
endmodule

// File: tb/blk_admit_bench.sv
`timescale 1ns/1ps
module blk_admit_bench;
   localparam int NSM   = 2;
   localparam int THR_W = 10;
   localparam int RPT_W = 7;
   localparam int SM_W  = 1;
   localparam int ID_W  = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst;
   logic             req_valid, req_ready;
   logic [THR_W-1:0] req_threads;
   logic [RPT_W-1:0] req_rpt;
   logic             grant_valid, reject;
   logic [SM_W-1:0]  grant_sm;
   logic [ID_W-1:0]  grant_id;
   logic             done_valid;
   logic [SM_W-1:0]  done_sm;
   logic [THR_W-1:0] done_threads;
   logic [RPT_W-1:0] done_rpt;

   blk_admit #(.NUM_SM(NSM), .RPT_W(RPT_W), .ID_W(ID_W)) u_blk_admit (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_threads(req_threads), .req_rpt(req_rpt),
      .grant_valid(grant_valid), .grant_sm(grant_sm), .grant_id(grant_id),
      .reject(reject),
      .done_valid(done_valid), .done_sm(done_sm),
      .done_threads(done_threads), .done_rpt(done_rpt)
   );

   int checks = 0;
   int errors = 0;
   int mb[NSM], mt[NSM], mr[NSM];
   int next_id;
   bit eg, erej, mfire;
   int esm, eid;
   int fs[64], ft[64], fr[64];
   int fh, fn;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pick(int t, int r);
      for (int i = 0; i < NSM; i++)
         if (mb[i] < 8 && mt[i] + t <= 768 && mr[i] + t * r <= 8192) return i;
      return -1;
   endfunction

   task automatic clear_model();
      for (int i = 0; i < NSM; i++) begin mb[i] = 0; mt[i] = 0; mr[i] = 0; end
      next_id = 0; eg = 0; erej = 0; fh = 0; fn = 0; mfire = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; req_valid = 0; done_valid = 0;
      req_threads = 1; req_rpt = 1; done_sm = 0; done_threads = 0; done_rpt = 0;
      @(negedge clk);
      @(negedge clk);
      rst = 0;
      clear_model();
   endtask

   // one cycle: check registered outputs from the previous cycle, drive, check ready
   task automatic step(string tag, bit v, int t, int r, bit pop);
      bit bad, er;
      int p;
      @(negedge clk);
      chk({tag, " R7 grant_valid"}, int'(grant_valid), int'(eg));
      if (eg) begin
         chk({tag, " R5 grant_sm"}, int'(grant_sm), esm);
         chk({tag, " R7 grant_id"}, int'(grant_id), eid);
      end
      chk({tag, " R1 reject"}, int'(reject), int'(erej));
      req_valid = v; req_threads = THR_W'(t); req_rpt = RPT_W'(r);
      done_valid = 0;
      if (pop && fn > 0) begin
         done_valid = 1; done_sm = SM_W'(fs[fh]);
         done_threads = THR_W'(ft[fh]); done_rpt = RPT_W'(fr[fh]);
      end
      #1;
      bad = (t == 0) || (t > 512);
      p = pick(t, r);
      er = bad || (p >= 0);
      chk({tag, " R6 req_ready"}, int'(req_ready), int'(er));
      eg = 0; erej = 0; mfire = v && er;
      if (pop && fn > 0) begin
         mb[fs[fh]] -= 1; mt[fs[fh]] -= ft[fh]; mr[fs[fh]] -= ft[fh] * fr[fh];
         fh = (fh + 1) % 64; fn--;
      end
      if (mfire) begin
         if (bad) erej = 1;
         else begin
            eg = 1; esm = p; eid = next_id; next_id = (next_id + 1) % 256;
            mb[p] += 1; mt[p] += t; mr[p] += t * r;
            fs[(fh + fn) % 64] = p; ft[(fh + fn) % 64] = t; fr[(fh + fn) % 64] = r; fn++;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      int ct, cr;
      rst = 1;
      do_reset();
      step("R10", 0, 1, 1, 0);
      step("R10", 0, 1, 1, 0);
      // R1: illegal sizes and the legal edges
      step("R1", 1, 0, 5, 0);
      step("R1", 1, 513, 1, 0);
      step("R1", 1, 1023, 3, 0);
      step("R1", 1, 512, 1, 0);
      step("R1", 1, 1, 1, 0);
      step("R8", 0, 1, 1, 1);
      step("R8", 0, 1, 1, 1);
      step("R8", 0, 1, 1, 0);
      // R2: block-count limit
      do_reset();
      for (int i = 0; i < 18; i++) step("R2", 1, 1, 1, 0);
      step("R8", 1, 1, 1, 1);
      step("R8", 1, 1, 1, 0);
      step("R8", 0, 1, 1, 0);
      // R3: thread limit, exact fill, in-order hold
      do_reset();
      for (int i = 0; i < 3; i++) step("R3", 1, 512, 1, 0);
      step("R6", 1, 512, 1, 0);
      step("R8", 1, 512, 1, 1);
      step("R8", 1, 512, 1, 0);
      do_reset();
      step("R3", 1, 512, 1, 0);
      step("R3", 1, 512, 1, 0);
      for (int i = 0; i < 3; i++) step("R3", 1, 256, 1, 0);
      step("R3", 0, 1, 1, 0);
      // R4: register limit
      do_reset();
      for (int i = 0; i < 4; i++) step("R4", 1, 128, 20, 0);
      do_reset();
      for (int i = 0; i < 4; i++) step("R4", 1, 256, 10, 0);
      do_reset();
      for (int i = 0; i < 5; i++) step("R4", 1, 256, 11, 0);
      step("R4", 0, 1, 1, 0);
      // R9: grant and completion on the same multiprocessor
      do_reset();
      step("R9", 1, 64, 4, 0);
      step("R9", 1, 64, 4, 1);
      for (int i = 0; i < 9; i++) step("R9", 1, 1, 1, 0);
      step("R9", 0, 1, 1, 0);
      // sweep
      do_reset();
      lf = 16'hACE1;
      ct = 1; cr = 1;
      for (int i = 0; i < 3000; i++) begin
         if (mfire || i == 0) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ct = int'(lf[9:0]) % 560;
            if (ct >= 1 && ct <= 512) begin
               cr = 1 + int'(lf[15:9]) % (8192 / ct);
               if (cr > 127) cr = 127;
            end else cr = int'(lf[15:9]);
         end
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step("R8 sweep", 1, ct, cr, lf[0]);
      end
      step("R8 sweep", 0, 1, 1, 0);
      step("R8 sweep", 0, 1, 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule